// File: doc/BRIEF.md
# Bytecode ALU Execution Unit

This unit executes one arithmetic or logic instruction of a 64-bit register-machine bytecode per clock. The surrounding pipeline presents an 8-bit opcode, the current values of the destination and source registers, and a 32-bit immediate, all qualified by `in_valid`. One clock later the unit returns the value to write back to the destination register, a write-enable, and a flag that marks the opcode as one the unit cannot execute. Fetch, the register file, memory access and branches are outside this block.

A single datapath serves two instruction classes. One works on 32-bit operands and zero-extends its result. The other works on full 64-bit operands. Bit 3 of the opcode picks either the source register or the immediate as the second operand. Division by zero, modulo by zero and oversized shift counts all produce defined results and never trap. A byte-order conversion operation uses the immediate to select a width of 16, 32 or 64 bits.

Top module: `bcalu_exec`

## Requirements
- R1: Opcode bits [2:0] give the class: 3'h4 is the 32-bit class and 3'h7 is the 64-bit class. Any other class value sets `bad_op`, clears `wb_en` and gives `wb_data` of zero. Each accepted input produces `out_valid` exactly one clock later. When `in_valid` is low, the next cycle has `out_valid`, `wb_en` and `bad_op` all low.
- R2: Opcode bit 3 set selects `src_val` as the second operand, and bit 3 clear selects the immediate. In the 64-bit class the immediate is sign-extended from bit 31.
- R3: In the 32-bit class both operands are cut to their low 32 bits before the operation, and the result is zero-extended into bits [63:32]. This holds for every operation except byte-order conversion.
- R4: Opcode bits [7:4] select the operation. Add (0x0), subtract (0x1), multiply (0x2), OR (0x4), AND (0x5) and XOR (0xa) wrap modulo the operand width.
- R5: The shift operations are left shift (0x6), logical right shift (0x7, fills with zeros) and arithmetic right shift (0xc, copies the operand's top bit). The count is the second operand masked to 5 bits in the 32-bit class and to 6 bits in the 64-bit class.
- R6: Unsigned divide (0x3) gives zero when the divisor is zero, where the divisor is taken after the 32-bit cut.
- R7: Unsigned modulo (0x9) with a zero divisor returns the destination operand: the full value in the 64-bit class, and its low 32 bits zero-extended in the 32-bit class.
- R8: Move (0xb) returns the second operand. Negate (0x8) returns the two's complement of the destination operand and ignores the second operand.
- R9: Byte-order conversion (0xd) works on the full destination value in either class. The immediate must be 16, 32 or 64, and names the width W. With opcode bit 3 set, the low W bits are byte-reversed. With bit 3 clear, they pass through unchanged. Bits above W are zero. Any other immediate sets `bad_op` and clears `wb_en`.
- R10: Operation values 0xe and 0xf set `bad_op`, clear `wb_en` and give `wb_data` of zero.
- R11: While reset is asserted, `out_valid`, `wb_en`, `bad_op` and `wb_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction present this cycle |
| op_code | input | 8 | Instruction opcode |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| imm_val | input | 32 | Instruction immediate |
| out_valid | output | 1 | Result present this cycle |
| wb_data | output | 64 | Value to write back |
| wb_en | output | 1 | Write back the result |
| bad_op | output | 1 | Opcode cannot be executed |

## Verification
Two functions can act on the same instruction: the 32-bit operand cut and the zero-divisor rule. This happens when a 32-bit divide or modulo uses a source register whose low half is zero but whose upper half is not. The bench sends exactly such instructions and expects zero for the divide and the untouched low destination half for the modulo. A design that tests the divisor for zero before the cut would return a quotient or remainder instead. A second overlap is between byte-order conversion and the illegal flag: a conversion instruction with a bad width immediate must raise `bad_op` and suppress the write in the same cycle.

// File: rtl/bcalu_pkg.sv
package bcalu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'h0,
        OP_SUB   = 4'h1,
        OP_MUL   = 4'h2,
        OP_DIV   = 4'h3,
        OP_OR    = 4'h4,
        OP_AND   = 4'h5,
        OP_LSH   = 4'h6,
        OP_RSH   = 4'h7,
        OP_NEG   = 4'h8,
        OP_MOD   = 4'h9,
        OP_XOR   = 4'ha,
        OP_MOV   = 4'hb,
        OP_ARSH  = 4'hc,
        OP_END   = 4'hd,
        OP_RSV_E = 4'he,
        OP_RSV_F = 4'hf
    } alu_op_e;

    localparam logic [2:0] CLS_NARROW = 3'h4;
    localparam logic [2:0] CLS_WIDE   = 3'h7;

    typedef struct packed {
        logic    cls_ok;
        logic    is_narrow;
        logic    use_reg;
        logic    to_big;
        alu_op_e code;
    } dec_t;

endpackage

// File: rtl/bcalu_decode.sv
module bcalu_decode
    import bcalu_pkg::*;
(
    input  logic [7:0] op_code,
    output dec_t       dec
);
    always_comb begin
        dec           = '0;
        dec.is_narrow = (op_code[2:0] == CLS_NARROW);
        dec.cls_ok    = dec.is_narrow || (op_code[2:0] == CLS_WIDE);
        dec.use_reg   = op_code[3];
        dec.to_big    = op_code[3];
        dec.code      = alu_op_e'(op_code[7:4]);
    end
endmodule

// File: rtl/bcalu_opsel.sv
module bcalu_opsel #(
    parameter int XLEN = 64,
    parameter int IMMW = 32
) (
    input  logic                 use_reg,
    input  logic [XLEN-1:0]      dst_val,
    input  logic [XLEN-1:0]      src_val,
    input  logic [IMMW-1:0]      imm_val,
    output logic [XLEN-1:0]      a_full,
    output logic [XLEN-1:0]      b_full,
    output logic [XLEN/2-1:0]    a_half,
    output logic [XLEN/2-1:0]    b_half
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] imm_sext;

    always_comb begin
        imm_sext = {{(XLEN-IMMW){imm_val[IMMW-1]}}, imm_val};
        a_full   = dst_val;
        b_full   = use_reg ? src_val : imm_sext;
        a_half   = a_full[HALF-1:0];
        b_half   = b_full[HALF-1:0];
    end
endmodule

// File: rtl/bcalu_core.sv
module bcalu_core
    import bcalu_pkg::*;
#(
    parameter int W = 64
) (
    input  alu_op_e      code,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam int SW = $clog2(W);

    logic [SW-1:0] sh;

    always_comb begin
        sh = b[SW-1:0];
        case (code)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_MUL:  y = a * b;
            OP_DIV:  y = (b == '0) ? '0 : a / b;
            OP_OR:   y = a | b;
            OP_AND:  y = a & b;
            OP_LSH:  y = a << sh;
            OP_RSH:  y = a >> sh;
            OP_NEG:  y = '0 - a;
            OP_MOD:  y = (b == '0) ? a : a % b;
            OP_XOR:  y = a ^ b;
            OP_MOV:  y = b;
            OP_ARSH: y = $signed(a) >>> sh;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/bcalu_swap.sv
module bcalu_swap #(
    parameter int XLEN = 64,
    parameter int IMMW = 32
) (
    input  logic [XLEN-1:0] v,
    input  logic            to_big,
    input  logic [IMMW-1:0] sel,
    output logic [XLEN-1:0] y,
    output logic            bad
);
    localparam int NW = 3;

    logic [XLEN-1:0] swp [NW];
    logic [XLEN-1:0] kep [NW];
    logic [NW-1:0]   hit;

    for (genvar g = 0; g < NW; g++) begin : g_width
        localparam int W = 16 << g;
        if (W <= XLEN) begin : g_ok
            logic [XLEN-1:0] swp_w;
            always_comb begin
                swp_w = '0;
                for (int k = 0; k < W / 8; k++) begin
                    swp_w[8*k +: 8] = v[W-8-8*k +: 8];
                end
            end
            assign swp[g] = swp_w;
            assign kep[g] = XLEN'(v[W-1:0]);
            assign hit[g] = (sel == IMMW'(W));
        end else begin : g_none
            assign swp[g] = '0;
            assign kep[g] = '0;
            assign hit[g] = 1'b0;
        end
    end

    always_comb begin
        y   = '0;
        bad = ~|hit;
        for (int g = 0; g < NW; g++) begin
            if (hit[g]) y = to_big ? swp[g] : kep[g];
        end
    end
endmodule

// File: rtl/bcalu_exec.sv
module bcalu_exec
    import bcalu_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int IMMW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [7:0]      op_code,
    input  logic [XLEN-1:0] dst_val,
    input  logic [XLEN-1:0] src_val,
    input  logic [IMMW-1:0] imm_val,
    output logic            out_valid,
    output logic [XLEN-1:0] wb_data,
    output logic            wb_en,
    output logic            bad_op
);
    localparam int HALF = XLEN / 2;

    typedef struct packed {
        logic            valid;
        logic            we;
        logic            bad;
        logic [XLEN-1:0] data;
    } stage_t;

    dec_t            dec;
    logic [XLEN-1:0] a_full, b_full, y_full, swp_y;
    logic [HALF-1:0] a_half, b_half, y_half;
    logic            swp_bad;
    logic            is_bad;
    stage_t          st_d, st_q;

    bcalu_decode u_dec (
        .op_code (op_code),
        .dec     (dec)
    );

    bcalu_opsel #(.XLEN(XLEN), .IMMW(IMMW)) u_opsel (
        .use_reg (dec.use_reg),
        .dst_val (dst_val),
        .src_val (src_val),
        .imm_val (imm_val),
        .a_full  (a_full),
        .b_full  (b_full),
        .a_half  (a_half),
        .b_half  (b_half)
    );

    bcalu_core #(.W(XLEN)) u_wide (
        .code (dec.code),
        .a    (a_full),
        .b    (b_full),
        .y    (y_full)
    );

    bcalu_core #(.W(HALF)) u_narrow (
        .code (dec.code),
        .a    (a_half),
        .b    (b_half),
        .y    (y_half)
    );

    bcalu_swap #(.XLEN(XLEN), .IMMW(IMMW)) u_swap (
        .v      (dst_val),
        .to_big (dec.to_big),
        .sel    (imm_val),
        .y      (swp_y),
        .bad    (swp_bad)
    );

    always_comb begin
        st_d   = '0;
        is_bad = !dec.cls_ok
               || (dec.code == OP_RSV_E)
               || (dec.code == OP_RSV_F)
               || ((dec.code == OP_END) && swp_bad);
        if (in_valid) begin
            st_d.valid = 1'b1;
            st_d.bad   = is_bad;
            st_d.we    = !is_bad;
            if (!is_bad) begin
                if (dec.code == OP_END)  st_d.data = swp_y;
                else if (dec.is_narrow)  st_d.data = XLEN'(y_half);
                else                     st_d.data = y_full;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign wb_en     = st_q.we;
    assign bad_op    = st_q.bad;
    assign wb_data   = st_q.data;

    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wb_en && !bad_op));

    a_r1_bad_class: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_code[2:0] != 3'h4) && (op_code[2:0] != 3'h7))
        |=> (bad_op && !wb_en));

    a_r3_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_code[2:0] == 3'h4) && (op_code[7:4] != 4'hd))
        |=> (wb_data[XLEN-1:HALF] == '0));

    a_r6_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_code == 8'h3f) && (src_val == '0))
        |=> (wb_data == '0));

    a_r7_mod_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_code == 8'h9f) && (src_val == '0))
        |=> (wb_data == $past(dst_val)));

    a_r8_mov: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_code == 8'hbf)) |=> (wb_data == $past(src_val)));

    a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_code[7:5] == 3'b111))
        |=> (bad_op && !wb_en && (wb_data == '0)));

endmodule

// File: tb/tb_bcalu_exec.sv
`timescale 1ns/1ps
module tb_bcalu_exec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  op_code = '0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic [31:0] imm_val = '0;
    logic        out_valid;
    logic [63:0] wb_data;
    logic        wb_en;
    logic        bad_op;

    int ncmp  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [63:0] data;
        logic        we;
        logic        bad;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    bcalu_exec dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_code   (op_code),
        .dst_val   (dst_val),
        .src_val   (src_val),
        .imm_val   (imm_val),
        .out_valid (out_valid),
        .wb_data   (wb_data),
        .wb_en     (wb_en),
        .bad_op    (bad_op)
    );

    task automatic send(input string tag, input logic [7:0] op,
                        input logic [63:0] d, input logic [63:0] s,
                        input logic [31:0] imm, input logic [63:0] exp_data,
                        input logic exp_we, input logic exp_bad);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        op_code  = op;
        dst_val  = d;
        src_val  = s;
        imm_val  = imm;
        e.data = exp_data;
        e.we   = exp_we;
        e.bad  = exp_bad;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic ok(input string tag, input logic [63:0] d, input logic [63:0] s,
                      input logic [31:0] imm, input logic [7:0] op, input logic [63:0] r);
        send(tag, op, d, s, imm, r, 1'b1, 1'b0);
    endtask

    task automatic ill(input string tag, input logic [7:0] op, input logic [31:0] imm);
        send(tag, op, 64'h1122_3344_5566_7788, 64'h5, imm, 64'h0, 1'b0, 1'b1);
    endtask

    always @(posedge clk) begin
        #1;
        if (rst_n && out_valid) begin
            ncmp++;
            if (exp_q.size() == 0) begin
                nfail++;
                $display("FAIL R1 unexpected result: actual data=%h, expected no output", wb_data);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (wb_data !== e.data || wb_en !== e.we || bad_op !== e.bad) begin
                    nfail++;
                    $display("FAIL %s: actual data=%h we=%b bad=%b, expected data=%h we=%b bad=%b",
                             e.tag, wb_data, wb_en, bad_op, e.data, e.we, e.bad);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        ncmp++;
        if (out_valid !== 1'b0 || wb_en !== 1'b0 || bad_op !== 1'b0 || wb_data !== 64'h0) begin
            nfail++;
            $display("FAIL R11 reset: actual v=%b we=%b bad=%b data=%h, expected all zero",
                     out_valid, wb_en, bad_op, wb_data);
        end
        rst_n = 1'b1;

        ok("R4 add64 wrap",      64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 32'h0, 8'h0f, 64'h1);
        ok("R3 add32 wrap",      64'h1_FFFF_FFFF, 64'h1, 32'h0, 8'h0c, 64'h0);
        ok("R2 add64 imm sext",  64'd10, 64'h0, 32'hFFFF_FFFF, 8'h07, 64'd9);
        ok("R2 add32 imm",       64'd10, 64'h0, 32'hFFFF_FFFF, 8'h04, 64'd9);
        ok("R4 sub64",           64'h0, 64'h1, 32'h0, 8'h1f, 64'hFFFF_FFFF_FFFF_FFFF);
        ok("R3 sub32 zext",      64'h0, 64'h0, 32'h1, 8'h14, 64'h0000_0000_FFFF_FFFF);
        ok("R4 mul64",           64'h1_0000_0001, 64'h1_0000_0000, 32'h0, 8'h2f, 64'h1_0000_0000);
        ok("R3 mul32",           64'h1_0000, 64'h1_0000, 32'h0, 8'h2c, 64'h0);
        ok("R6 div64",           64'd100, 64'd7, 32'h0, 8'h3f, 64'd14);
        ok("R6 div64 by zero",   64'd100, 64'h0, 32'h0, 8'h3f, 64'h0);
        ok("R6 div32 cut zero",  64'd100, 64'h1_0000_0000, 32'h0, 8'h3c, 64'h0);
        ok("R7 mod64",           64'd100, 64'd7, 32'h0, 8'h9f, 64'd2);
        ok("R7 mod64 by zero",   64'hDEAD_BEEF_0000_1234, 64'h0, 32'h0, 8'h9f, 64'hDEAD_BEEF_0000_1234);
        ok("R7 mod32 cut zero",  64'hABCD_0000_0000_0064, 64'h5_0000_0000, 32'h0, 8'h9c, 64'h64);
        ok("R2 or64 imm sext",   64'h0, 64'h0, 32'h8000_0000, 8'h47, 64'hFFFF_FFFF_8000_0000);
        ok("R4 and32",           64'hFFFF_FFFF_F0F0_F0F0, 64'hFFFF_FFFF_FF00_FF00, 32'h0, 8'h5c, 64'hF000_F000);
        ok("R4 xor64",           64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_FFFF_0000_0000, 32'h0, 8'haf, 64'h5555_5555_AAAA_AAAA);
        ok("R5 lsh64 mask",      64'h1, 64'd65, 32'h0, 8'h6f, 64'h2);
        ok("R5 lsh32 mask",      64'h1, 64'd33, 32'h0, 8'h6c, 64'h2);
        ok("R5 lsh32 drop top",  64'h8000_0001, 64'h0, 32'h1, 8'h64, 64'h2);
        ok("R5 rsh64",           64'h8000_0000_0000_0000, 64'd63, 32'h0, 8'h7f, 64'h1);
        ok("R5 arsh64",          64'h8000_0000_0000_0000, 64'd63, 32'h0, 8'hcf, 64'hFFFF_FFFF_FFFF_FFFF);
        ok("R5 arsh32",          64'h8000_0000, 64'd4, 32'h0, 8'hcc, 64'hF800_0000);
        ok("R5 rsh32 imm mask",  64'h8000_0000, 64'h0, 32'd36, 8'h74, 64'h0800_0000);
        ok("R8 mov64 imm",       64'h0, 64'h0, 32'hFFFF_FFFE, 8'hb7, 64'hFFFF_FFFF_FFFF_FFFE);
        ok("R8 mov32 reg",       64'h0, 64'h1234_5678_9ABC_DEF0, 32'h0, 8'hbc, 64'h9ABC_DEF0);
        ok("R8 neg64",           64'd5, 64'h0, 32'd123, 8'h87, 64'hFFFF_FFFF_FFFF_FFFB);
        ok("R8 neg32",           64'd5, 64'h0, 32'd123, 8'h84, 64'hFFFF_FFFB);
        ok("R9 swap16",          64'h1122_3344_5566_7788, 64'h0, 32'd16, 8'hdc, 64'h8877);
        ok("R9 swap32",          64'h1122_3344_5566_7788, 64'h0, 32'd32, 8'hdc, 64'h8877_6655);
        ok("R9 swap64 wide",     64'h1122_3344_5566_7788, 64'h0, 32'd64, 8'hdf, 64'h8877_6655_4433_2211);
        ok("R9 keep16",          64'h1122_3344_5566_7788, 64'h0, 32'd16, 8'hd4, 64'h7788);
        ok("R9 keep32",          64'h1122_3344_5566_7788, 64'h0, 32'd32, 8'hd4, 64'h5566_7788);
        ill("R9 bad width",      8'hdc, 32'd8);
        ill("R10 reserved e",    8'he7, 32'h0);
        ill("R10 reserved f",    8'hff, 32'h0);
        ill("R1 bad class",      8'h0d, 32'h0);

        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        ncmp++;
        if (out_valid !== 1'b0 || wb_en !== 1'b0 || bad_op !== 1'b0) begin
            nfail++;
            $display("FAIL R1 idle: actual v=%b we=%b bad=%b, expected 0 0 0",
                     out_valid, wb_en, bad_op);
        end
        ncmp++;
        if (exp_q.size() != 0) begin
            nfail++;
            $display("FAIL R1 missing results: actual %0d pending, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            ncmp++;
            nfail++;
            $display("FAIL R1 watchdog: actual run still active, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
            $finish;
        end
    end

endmodule